// File: doc/BRIEF.md
# Bus Parity Generator and Checker

This block produces and verifies the parity bit of a 32-bit multiplexed address/data bus with four command/byte-enable lines. While the agent drives the bus, the block computes the parity bit that makes the total number of ones across the 32 address/data lines, the four command/byte-enable lines and the parity bit itself even. It presents that bit in the clock after the values it covers.

While the agent receives, the block recomputes parity over the sampled address/data and command/byte-enable values of an address phase or a completed data phase. It compares the result with the parity bit sampled one clock later. A mismatch in a data phase is reported on the active-low data parity error line. A mismatch in an address phase is reported on the active-low system error line. Each report obeys its own enable bits from the command register, and the status flags are raised as set pulses for the status register.

The block works on the sampled bus values of a bus clocked at up to 33 MHz. Pad drivers and electrical timing sit outside it.

Top module: `pci_parity_unit`

## Requirements
- R1: While `par_oe` is high, `par_out` equals the XOR of all 36 bits of `ad_in` and `cbe_in` from the previous clock, so that those 36 bits plus `par_out` hold an even number of ones.
- R2: `par_oe` is high in a clock exactly when `drive_ad` was high in the previous clock. Parity is therefore released one clock after the agent stops driving.
- R3: A receive-side check is armed in a clock where `drive_ad` is 0 and either `addr_phase` is 1 (address check; this wins when both are set) or `data_valid` is 1 (data check). The check compares `par_in` in the next clock with the parity of the armed values. While `drive_ad` is 1, nothing is checked.
- R4: For a data check that mismatches, `perr_n` is 0 in the clock two clocks after the armed data phase. This happens only if `cmd_per_en` was 1 in the clock where `par_in` was compared. Otherwise `perr_n` is 1.
- R5: `perr_oe` is high in each clock where `perr_n` is 0 and in the one clock after it, where `perr_n` is 1. It is low at all other times.
- R6: For an address check that mismatches, `serr_n` is 0 for one clock, two clocks after the armed address phase. This happens only if both `cmd_per_en` and `cmd_serr_en` were 1 in the comparing clock.
- R7: `serr_oe` is high only in clocks where `serr_n` is 0.
- R8: `sts_dpe` pulses high, in the same clock that a report would occur, for every mismatch of either kind, whatever the enable bits are.
- R9: `sts_sse` is high exactly in the clocks where `serr_n` is 0.
- R10: After reset, `par_oe`, `perr_oe`, `serr_oe`, `sts_dpe` and `sts_sse` are 0, and `perr_n` and `serr_n` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ad_in | input | 32 | Address/data bus value this clock |
| cbe_in | input | 4 | Command/byte-enable value this clock |
| par_in | input | 1 | Sampled parity line |
| drive_ad | input | 1 | Agent drives address/data this clock |
| addr_phase | input | 1 | This clock is an address phase |
| data_valid | input | 1 | A data phase completes this clock |
| cmd_per_en | input | 1 | Command register parity error response enable |
| cmd_serr_en | input | 1 | Command register system error enable |
| par_out | output | 1 | Generated parity bit |
| par_oe | output | 1 | Parity output enable |
| perr_n | output | 1 | Data parity error, active low |
| perr_oe | output | 1 | Data parity error output enable |
| serr_n | output | 1 | System error, active low |
| serr_oe | output | 1 | System error output enable |
| sts_dpe | output | 1 | Set pulse for detected parity error flag |
| sts_sse | output | 1 | Set pulse for signalled system error flag |

## Verification
Driving patterns of all zeros, all ones and single walking bits separate a correct even-parity fold from an inverted or partial one. They also show whether the parity enable tracks the drive qualifier with exactly one clock of lag. Receive patterns give correct parity and flipped parity under each combination of the two enable bits. These patterns tell the data-phase report apart from the address-phase report, and tell the gated lines apart from the always-set detected flag. Back-to-back data errors, an address and data qualifier raised together, and phases that arrive while the agent drives exercise the release clock, the priority and the suppression rules. A long random stretch is then compared against the reference model on every clock.

// File: rtl/pci_par_pkg.sv
package pci_par_pkg;
  // Fold of a vector to one bit: 1 when the count of ones is odd.
  function automatic logic odd_ones(input logic [63:0] v);
    return ^v;
  endfunction
endpackage

// File: rtl/pci_par_gen.sv
module pci_par_gen #(
  parameter int AD_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [AD_W-1:0]      ad,
  input  logic [AD_W/8-1:0]    cbe,
  input  logic                 drive,
  output logic                 par_out,
  output logic                 par_oe
);
  import pci_par_pkg::*;
  localparam int CBE_W = AD_W / 8;
  localparam int PAD_W = 64 - AD_W - CBE_W;

  logic gen_bit;
  assign gen_bit = odd_ones({{PAD_W{1'b0}}, ad, cbe});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      par_out <= 1'b0;
      par_oe  <= 1'b0;
    end else begin
      par_out <= gen_bit;
      par_oe  <= drive;
    end
  end

  // R2
  oe_on_chk: assert property (@(posedge clk) disable iff (!rst_n) drive |=> par_oe);
  // R2
  oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n) !drive |=> !par_oe);
  // R1
  even_total_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drive |=> ($countones({$past(ad), $past(cbe), par_out}) % 2 == 0));
endmodule

// File: rtl/pci_par_check.sv
module pci_par_check #(
  parameter int AD_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [AD_W-1:0]      ad,
  input  logic [AD_W/8-1:0]    cbe,
  input  logic                 par_in,
  input  logic                 drive,
  input  logic                 addr_phase,
  input  logic                 data_valid,
  output logic                 addr_err,
  output logic                 data_err
);
  import pci_par_pkg::*;
  localparam int CBE_W = AD_W / 8;
  localparam int PAD_W = 64 - AD_W - CBE_W;

  logic pend_addr, pend_data, pend_par;
  logic arm_addr, arm_data;

  assign arm_addr = !drive && addr_phase;
  assign arm_data = !drive && !addr_phase && data_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_addr <= 1'b0;
      pend_data <= 1'b0;
      pend_par  <= 1'b0;
    end else begin
      pend_addr <= arm_addr;
      pend_data <= arm_data;
      pend_par  <= odd_ones({{PAD_W{1'b0}}, ad, cbe});
    end
  end

  assign addr_err = pend_addr && (pend_par != par_in);
  assign data_err = pend_data && (pend_par != par_in);

  // R3
  no_check_on_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drive |=> !addr_err && !data_err);
  // R3
  one_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(addr_err && data_err));
endmodule

// File: rtl/pci_err_report.sv
module pci_err_report (
  input  logic clk,
  input  logic rst_n,
  input  logic addr_err,
  input  logic data_err,
  input  logic per_en,
  input  logic serr_en,
  output logic perr_n,
  output logic perr_oe,
  output logic serr_n,
  output logic serr_oe,
  output logic sts_dpe,
  output logic sts_sse
);
  logic perr_asrt, perr_hold, serr_asrt, dpe_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      perr_asrt <= 1'b0;
      perr_hold <= 1'b0;
      serr_asrt <= 1'b0;
      dpe_q     <= 1'b0;
    end else begin
      perr_asrt <= data_err && per_en;
      perr_hold <= perr_asrt;
      serr_asrt <= addr_err && per_en && serr_en;
      dpe_q     <= addr_err || data_err;
    end
  end

  assign perr_n  = !perr_asrt;
  assign perr_oe = perr_asrt || perr_hold;
  assign serr_n  = !serr_asrt;
  assign serr_oe = serr_asrt;
  assign sts_dpe = dpe_q;
  assign sts_sse = serr_asrt;

  // R5
  perr_release_chk: assert property (@(posedge clk) disable iff (!rst_n) !perr_n |=> perr_oe);
  // R7
  serr_oe_chk: assert property (@(posedge clk) disable iff (!rst_n) serr_oe |-> !serr_n);
  // R9
  sse_with_serr_chk: assert property (@(posedge clk) disable iff (!rst_n) !serr_n |-> sts_sse);
  // R8
  dpe_follows_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_err || data_err) |=> sts_dpe);
  // R6
  serr_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_err && !(per_en && serr_en)) |=> serr_n);
endmodule

// File: rtl/pci_parity_unit.sv
module pci_parity_unit #(
  parameter int AD_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [AD_W-1:0]      ad_in,
  input  logic [AD_W/8-1:0]    cbe_in,
  input  logic                 par_in,
  input  logic                 drive_ad,
  input  logic                 addr_phase,
  input  logic                 data_valid,
  input  logic                 cmd_per_en,
  input  logic                 cmd_serr_en,
  output logic                 par_out,
  output logic                 par_oe,
  output logic                 perr_n,
  output logic                 perr_oe,
  output logic                 serr_n,
  output logic                 serr_oe,
  output logic                 sts_dpe,
  output logic                 sts_sse
);
  logic addr_err, data_err;

  pci_par_gen #(.AD_W(AD_W)) u_gen (
    .clk(clk), .rst_n(rst_n), .ad(ad_in), .cbe(cbe_in), .drive(drive_ad),
    .par_out(par_out), .par_oe(par_oe)
  );

  pci_par_check #(.AD_W(AD_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ad(ad_in), .cbe(cbe_in), .par_in(par_in),
    .drive(drive_ad), .addr_phase(addr_phase), .data_valid(data_valid),
    .addr_err(addr_err), .data_err(data_err)
  );

  pci_err_report u_rep (
    .clk(clk), .rst_n(rst_n), .addr_err(addr_err), .data_err(data_err),
    .per_en(cmd_per_en), .serr_en(cmd_serr_en),
    .perr_n(perr_n), .perr_oe(perr_oe), .serr_n(serr_n), .serr_oe(serr_oe),
    .sts_dpe(sts_dpe), .sts_sse(sts_sse)
  );

  // R4
  perr_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_err && cmd_per_en) |=> !perr_n);
  // R10
  reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> !par_oe && !perr_oe && !serr_oe);
endmodule

// File: tb/test_pci_parity_unit.sv
`timescale 1ns/1ps
module test_pci_parity_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] ad_in = '0;
  logic [3:0]  cbe_in = '0;
  logic par_in = 1'b0, drive_ad = 1'b0, addr_phase = 1'b0, data_valid = 1'b0;
  logic cmd_per_en = 1'b0, cmd_serr_en = 1'b0;
  logic par_out, par_oe, perr_n, perr_oe, serr_n, serr_oe, sts_dpe, sts_sse;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pci_parity_unit i_pci_parity_unit (
    .clk(clk), .rst_n(rst_n), .ad_in(ad_in), .cbe_in(cbe_in), .par_in(par_in),
    .drive_ad(drive_ad), .addr_phase(addr_phase), .data_valid(data_valid),
    .cmd_per_en(cmd_per_en), .cmd_serr_en(cmd_serr_en),
    .par_out(par_out), .par_oe(par_oe), .perr_n(perr_n), .perr_oe(perr_oe),
    .serr_n(serr_n), .serr_oe(serr_oe), .sts_dpe(sts_dpe), .sts_sse(sts_sse)
  );

  // reference model state
  bit m_par, m_paroe, m_pend, m_pkind_addr, m_ppar;
  bit m_perr, m_perr_prev, m_serr, m_dpe;
  logic [31:0] prev_ad = '0;
  logic [3:0]  prev_cbe = '0;

  function automatic bit ref_par(logic [31:0] a, logic [3:0] c);
    int n = 0;
    for (int i = 0; i < 32; i++) n += a[i];
    for (int i = 0; i < 4; i++) n += c[i];
    return bit'(n % 2);
  endfunction

  task automatic check(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step();
    bit err;
    m_perr_prev = m_perr;
    err = m_pend && (m_ppar != par_in);
    m_perr = err && !m_pkind_addr && cmd_per_en;
    m_serr = err && m_pkind_addr && cmd_per_en && cmd_serr_en;
    m_dpe  = err;
    m_pend = !drive_ad && (addr_phase || data_valid);
    m_pkind_addr = addr_phase;
    m_ppar = ref_par(ad_in, cbe_in);
    m_par = ref_par(ad_in, cbe_in);
    m_paroe = drive_ad;
  endtask

  task automatic compare();
    check("R2 par_oe", par_oe, m_paroe);
    if (m_paroe) check("R1 par_out", par_out, m_par);
    check("R4 perr_n", perr_n, !m_perr);
    check("R5 perr_oe", perr_oe, m_perr || m_perr_prev);
    check("R6 serr_n", serr_n, !m_serr);
    check("R7 serr_oe", serr_oe, m_serr);
    check("R8 sts_dpe", sts_dpe, m_dpe);
    check("R9 sts_sse", sts_sse, m_serr);
  endtask

  // apply inputs at a negedge, then advance one clock and compare
  task automatic cyc(bit drv, bit ap, bit dv, logic [31:0] a, logic [3:0] c, bit bad);
    par_in = ref_par(prev_ad, prev_cbe) ^ bad;
    drive_ad = drv; addr_phase = ap; data_valid = dv; ad_in = a; cbe_in = c;
    prev_ad = a; prev_cbe = c;
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10 reset state
    check("R10 par_oe", par_oe, 1'b0);
    check("R10 perr_n", perr_n, 1'b1);
    check("R10 perr_oe", perr_oe, 1'b0);
    check("R10 serr_n", serr_n, 1'b1);
    check("R10 serr_oe", serr_oe, 1'b0);
    check("R10 sts_dpe", sts_dpe, 1'b0);
    check("R10 sts_sse", sts_sse, 1'b0);
    rst_n = 1'b1;

    // R1 R2: drive patterns, then stop driving
    cyc(1, 0, 0, 32'h0, 4'h0, 0);
    cyc(1, 0, 0, 32'hFFFF_FFFF, 4'hF, 0);
    for (int i = 0; i < 36; i++)
      cyc(1, 0, 0, (i < 32) ? (32'h1 << i) : 32'h0, (i >= 32) ? (4'h1 << (i - 32)) : 4'h0, 0);
    cyc(0, 0, 0, 32'h1234_5678, 4'h3, 0);
    cyc(0, 0, 0, 32'h0, 4'h0, 0);

    // R3 R4 R5: data phases with parity response on
    cmd_per_en = 1; cmd_serr_en = 0;
    cyc(0, 0, 1, 32'hA5A5_0001, 4'h6, 0);
    cyc(0, 0, 0, 32'h0, 4'h0, 0);          // correct parity
    cyc(0, 0, 1, 32'h0F0F_F0F0, 4'h1, 0);
    cyc(0, 0, 0, 32'h0, 4'h0, 1);          // bad parity -> perr
    cyc(0, 0, 0, 32'h0, 4'h0, 0);
    cyc(0, 0, 0, 32'h0, 4'h0, 0);
    // back-to-back data errors
    cyc(0, 0, 1, 32'h1, 4'h0, 0);
    cyc(0, 0, 1, 32'h3, 4'h0, 1);
    cyc(0, 0, 0, 32'h0, 4'h0, 1);
    cyc(0, 0, 0, 32'h0, 4'h0, 0);
    cyc(0, 0, 0, 32'h0, 4'h0, 0);
    // R8: response disabled, only the detected flag
    cmd_per_en = 0;
    cyc(0, 0, 1, 32'h7, 4'h2, 0);
    cyc(0, 0, 0, 32'h0, 4'h0, 1);
    cyc(0, 0, 0, 32'h0, 4'h0, 0);
    cyc(0, 0, 0, 32'h0, 4'h0, 0);

    // R6 R7 R9: address phases under each enable combination
    for (int e = 0; e < 4; e++) begin
      cmd_per_en = e[0]; cmd_serr_en = e[1];
      cyc(0, 1, 0, 32'hDEAD_BEEF, 4'h7, 0);
      cyc(0, 0, 0, 32'h0, 4'h0, 1);
      cyc(0, 0, 0, 32'h0, 4'h0, 0);
      cyc(0, 0, 0, 32'h0, 4'h0, 0);
    end
    // R3: address wins over data when both set
    cmd_per_en = 1; cmd_serr_en = 1;
    cyc(0, 1, 1, 32'h8000_0000, 4'hC, 0);
    cyc(0, 0, 0, 32'h0, 4'h0, 1);
    cyc(0, 0, 0, 32'h0, 4'h0, 0);
    cyc(0, 0, 0, 32'h0, 4'h0, 0);
    // R3: phases while driving are not checked
    cyc(1, 1, 0, 32'h55, 4'h0, 0);
    cyc(1, 0, 1, 32'h0, 4'h0, 1);
    cyc(0, 0, 0, 32'h0, 4'h0, 1);
    cyc(0, 0, 0, 32'h0, 4'h0, 0);
    cyc(0, 0, 0, 32'h0, 4'h0, 0);

    // random stretch
    for (int k = 0; k < 400; k++) begin
      cmd_per_en = 1'($urandom); cmd_serr_en = 1'($urandom);
      cyc(1'($urandom), ($urandom % 4) == 0, 1'($urandom), $urandom, 4'($urandom),
          ($urandom % 3) == 0);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule